// File: doc/BRIEF.md
# Prescaled Up/Down Counter Cell

This block is a programmable counter/timer cell for a small mixed-signal logic fabric. A 4-bit source code picks one of three timing sources: the main clock through a divide-by-N prescaler, a ring-oscillator clock, or a low-frequency clock. Every event from the chosen source becomes a single-cycle count strobe in the main clock domain. On each strobe the counter steps toward a programmed limit or toward zero, depending on the direction input, unless the hold input is high. When it reaches the end for the current direction, it reloads and raises a one-cycle terminal pulse.

A reset input clears the count, or preloads it with the programmed limit. It can respond to either edge, to the falling edge only, to the rising edge only, or to a high level. All configuration inputs are static: source code, reset sensitivity, reset-value choice and limit. A parameter selects a reduced 3-bit source decoder in place of the full 4-bit one. An unsupported source code stops the counter and raises an error flag.

The alternate clocks and the reset input are synchronized into the main clock domain before use. Control and status pins are plain levels and pulses, so there is no handshake at the edge of the block.

Top module: `prescaled_updown_counter`

## Requirements
- R1: With WIDE_SEL=1 the source code decodes as follows. 0, 1, 2, 3 and 4 select the main clock divided by 1, 4, 12, 24 and 64. 8 selects the ring clock. 10 selects the low-frequency clock. Each strobe advances the count by one step.
- R2: With WIDE_SEL=0 the source code decodes as follows. 0, 1, 2 and 3 select the main clock divided by 1, 4, 24 and 64. 4 selects the low-frequency clock and 6 selects the ring clock. Any code with bit 3 set is unsupported.
- R3: The reset sensitivity code is decoded as follows. 0 acts on both edges, 1 on the falling edge only and 2 on the rising edge only. The reset input passes through two synchronizer stages, and an edge loads the reset value on the third main-clock edge after it. That load takes priority over a count step or wrap on the same strobe, and no terminal pulse is produced.
- R4: With sensitivity code 3 (level), the count is held at the reset value on every main-clock edge while the synchronized reset input is high, whatever the hold and strobe inputs are.
- R5: When the reset-value input is 0, a reset loads zero. When it is 1, a reset loads the programmed limit.
- R6: While the hold input is high, a strobe leaves the count unchanged.
- R7: When the direction input is 1, a strobe increments the count. If the count is at or above the limit, the strobe instead sets it to zero and term_o pulses high for one cycle. count_o and the limit are both DEPTH bits wide.
- R8: When the direction input is 0, a strobe decrements the count. If the count is zero, the strobe instead reloads the limit and term_o pulses high for one cycle.
- R9: When the source code changes, the prescaler phase restarts. With the new divide ratio N, the first strobe comes on the (N+1)th main-clock edge after the change is seen.
- R10: An unsupported source code sets err_o one cycle later and stops all count strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| ring_clk_i | input | 1 | Ring-oscillator clock, asynchronous |
| lf_clk_i | input | 1 | Low-frequency clock, asynchronous |
| clk_sel_i | input | 4 | Timing source and prescale code |
| rst_mode_i | input | 2 | Reset sensitivity code |
| rst_to_cnt_i | input | 1 | Reset value select: 0 zero, 1 limit |
| cnt_val_i | input | DEPTH | Programmed limit |
| rst_in_i | input | 1 | Counter reset request, asynchronous |
| keep_i | input | 1 | Hold the count |
| up_i | input | 1 | Direction: 1 up, 0 down |
| term_o | output | 1 | One-cycle terminal pulse |
| err_o | output | 1 | Unsupported source code |
| count_o | output | DEPTH | Current count |

## Verification
A reset load and a count step, or a terminal wrap, can fall on the same strobe. The bench provokes this with the divide-by-1 source, hold low and a limit of 2. A reset edge is driven so that its load lands on exactly the strobe where the count would wrap. The expected count is computed cycle by cycle for every sensitivity and reset-value pair. The bench requires that the load wins and that no terminal pulse appears on that cycle.

// File: rtl/pudc_pkg.sv
package pudc_pkg;
  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_RING = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    RM_BOTH  = 2'd0,
    RM_FALL  = 2'd1,
    RM_RISE  = 2'd2,
    RM_LEVEL = 2'd3
  } rmode_e;

  localparam int PDIV_W = 7;

  typedef struct packed {
    src_e              src;
    logic [PDIV_W-1:0] div;
  } srcsel_t;
endpackage

// File: rtl/pudc_sync.sv
module pudc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pudc_src_decode.sv
module pudc_src_decode import pudc_pkg::*; #(
  parameter bit WIDE_SEL = 1'b1
) (
  input  logic [3:0] code_i,
  output srcsel_t    sel_o
);
  if (WIDE_SEL) begin : g_wide
    always_comb begin
      sel_o.src = SRC_MAIN;
      sel_o.div = PDIV_W'(1);
      case (code_i)
        4'd0:  sel_o.div = PDIV_W'(1);
        4'd1:  sel_o.div = PDIV_W'(4);
        4'd2:  sel_o.div = PDIV_W'(12);
        4'd3:  sel_o.div = PDIV_W'(24);
        4'd4:  sel_o.div = PDIV_W'(64);
        4'd8:  sel_o.src = SRC_RING;
        4'd10: sel_o.src = SRC_SLOW;
        default: sel_o.src = SRC_NONE;
      endcase
    end
  end else begin : g_narrow
    always_comb begin
      sel_o.src = SRC_MAIN;
      sel_o.div = PDIV_W'(1);
      case (code_i)
        4'd0: sel_o.div = PDIV_W'(1);
        4'd1: sel_o.div = PDIV_W'(4);
        4'd2: sel_o.div = PDIV_W'(24);
        4'd3: sel_o.div = PDIV_W'(64);
        4'd4: sel_o.src = SRC_SLOW;
        4'd6: sel_o.src = SRC_RING;
        default: sel_o.src = SRC_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pudc_prescaler.sv
module pudc_prescaler import pudc_pkg::*; (
  input  logic    clk,
  input  logic    rst_n,
  input  srcsel_t sel_i,
  input  logic    restart_i,
  input  logic    ring_s_i,
  input  logic    slow_s_i,
  output logic    tick_o
);
  logic [PDIV_W-1:0] phase;
  logic              ring_d, slow_d;
  logic              main_hit;

  assign main_hit = (phase >= sel_i.div - PDIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      ring_d <= 1'b0;
      slow_d <= 1'b0;
    end else begin
      ring_d <= ring_s_i;
      slow_d <= slow_s_i;
      if (restart_i || sel_i.src != SRC_MAIN) phase <= '0;
      else if (main_hit)                      phase <= '0;
      else                                    phase <= phase + PDIV_W'(1);
    end
  end

  always_comb begin
    tick_o = 1'b0;
    if (!restart_i) begin
      case (sel_i.src)
        SRC_MAIN: tick_o = main_hit;
        SRC_RING: tick_o = ring_s_i & ~ring_d;
        SRC_SLOW: tick_o = slow_s_i & ~slow_d;
        default:  tick_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pudc_reset_ctl.sv
module pudc_reset_ctl import pudc_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       req_s_i,
  input  logic       tick_i,
  output logic       edge_hit_o,
  output logic       level_hit_o
);
  logic   prev;
  logic   rose, fell;
  rmode_e mode;

  assign mode = rmode_e'(mode_i);
  assign rose = tick_i & req_s_i & ~prev;
  assign fell = tick_i & ~req_s_i & prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev <= 1'b0;
    else if (tick_i) prev <= req_s_i;
  end

  always_comb begin
    case (mode)
      RM_BOTH: edge_hit_o = rose | fell;
      RM_FALL: edge_hit_o = fell;
      RM_RISE: edge_hit_o = rose;
      default: edge_hit_o = 1'b0;
    endcase
    level_hit_o = (mode == RM_LEVEL) && req_s_i;
  end
endmodule

// File: rtl/pudc_core.sv
module pudc_core #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             level_hit_i,
  input  logic             edge_hit_i,
  input  logic             keep_i,
  input  logic             up_i,
  input  logic             load_lim_i,
  input  logic [DEPTH-1:0] limit_i,
  output logic [DEPTH-1:0] count_o,
  output logic             term_o
);
  logic [DEPTH-1:0] rst_val;

  assign rst_val = load_lim_i ? limit_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
      term_o  <= 1'b0;
    end else begin
      term_o <= 1'b0;
      if (level_hit_i) begin
        count_o <= rst_val;
      end else if (tick_i) begin
        if (edge_hit_i) begin
          count_o <= rst_val;
        end else if (!keep_i) begin
          if (up_i) begin
            if (count_o >= limit_i) begin
              count_o <= '0;
              term_o  <= 1'b1;
            end else begin
              count_o <= count_o + DEPTH'(1);
            end
          end else if (count_o == '0) begin
            count_o <= limit_i;
            term_o  <= 1'b1;
          end else begin
            count_o <= count_o - DEPTH'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/prescaled_updown_counter.sv
module prescaled_updown_counter import pudc_pkg::*; #(
  parameter int DEPTH       = 8,
  parameter bit WIDE_SEL    = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_clk_i,
  input  logic             lf_clk_i,
  input  logic [3:0]       clk_sel_i,
  input  logic [1:0]       rst_mode_i,
  input  logic             rst_to_cnt_i,
  input  logic [DEPTH-1:0] cnt_val_i,
  input  logic             rst_in_i,
  input  logic             keep_i,
  input  logic             up_i,
  output logic             term_o,
  output logic             err_o,
  output logic [DEPTH-1:0] count_o
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in, synced;
  srcsel_t          sel;
  logic [3:0]       sel_q;
  logic             restart, tick, edge_hit, level_hit;

  assign raw_in = {rst_in_i, lf_clk_i, ring_clk_i};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    pudc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in[g]), .q(synced[g])
    );
  end

  pudc_src_decode #(.WIDE_SEL(WIDE_SEL)) u_dec (
    .code_i(clk_sel_i), .sel_o(sel)
  );

  assign restart = (sel_q != clk_sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      err_o <= 1'b0;
    end else begin
      sel_q <= clk_sel_i;
      err_o <= (sel.src == SRC_NONE);
    end
  end

  pudc_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .restart_i(restart),
    .ring_s_i(synced[0]), .slow_s_i(synced[1]), .tick_o(tick)
  );

  pudc_reset_ctl u_rctl (
    .clk(clk), .rst_n(rst_n), .mode_i(rst_mode_i), .req_s_i(synced[2]),
    .tick_i(tick), .edge_hit_o(edge_hit), .level_hit_o(level_hit)
  );

  pudc_core #(.DEPTH(DEPTH)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .level_hit_i(level_hit),
    .edge_hit_i(edge_hit), .keep_i(keep_i), .up_i(up_i),
    .load_lim_i(rst_to_cnt_i), .limit_i(cnt_val_i),
    .count_o(count_o), .term_o(term_o)
  );
endmodule

// File: rtl/pudc_checker.sv
module pudc_checker #(
  parameter int DEPTH  = 8,
  parameter int STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       rst_mode_i,
  input logic             rst_to_cnt_i,
  input logic [DEPTH-1:0] cnt_val_i,
  input logic             rst_in_i,
  input logic             term_o,
  input logic             err_o,
  input logic [DEPTH-1:0] count_o
);
  typedef logic [DEPTH-1:0] cnt_t;
  logic [3:0] hi_run;
  cnt_t       rst_val;

  assign rst_val = rst_to_cnt_i ? cnt_val_i : '0;

  // consecutive cycles the reset request has been seen high since chip reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_run <= '0;
    else if (!rst_in_i)        hi_run <= '0;
    else if (hi_run != 4'hF)   hi_run <= hi_run + 4'd1;
  end

  assert_hold_on_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $stable(count_o) || rst_mode_i == 2'd3);

  assert_term_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |-> (count_o == '0 || count_o == cnt_val_i));

  // R8: every change is a single step, or a reload to zero or the limit
  assert_step_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o != $past(count_o)) |->
      (cnt_t'(count_o - $past(count_o)) == cnt_t'(1) ||
       cnt_t'($past(count_o) - count_o) == cnt_t'(1) ||
       count_o == '0 || count_o == cnt_val_i));

  assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_mode_i == 2'd3 && rst_in_i && int'(hi_run) >= STAGES + 1) |->
      count_o == rst_val);
endmodule

bind prescaled_updown_counter pudc_checker #(.DEPTH(DEPTH), .STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_mode_i(rst_mode_i), .rst_to_cnt_i(rst_to_cnt_i),
  .cnt_val_i(cnt_val_i), .rst_in_i(rst_in_i), .term_o(term_o), .err_o(err_o),
  .count_o(count_o)
);

// File: tb/test_prescaled_updown_counter.sv
`timescale 1ns/1ps
module test_prescaled_updown_counter;
  logic       clk = 1'b0, rst_n = 1'b0, ring = 1'b0, lf = 1'b0;
  logic [3:0] sel = 4'd0;
  logic [1:0] rmode = 2'd2;
  logic       rstv = 1'b0, rin = 1'b0, keep = 1'b1, up = 1'b1;
  logic [7:0] mval = 8'd0;
  logic       term_w, err_w, term_n, err_n;
  logic [7:0] cnt_w, cnt_n;
  logic [7:0] mq;
  logic       mt;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prescaled_updown_counter #(.DEPTH(8), .WIDE_SEL(1'b1)) i_prescaled_updown_counter (
    .clk(clk), .rst_n(rst_n), .ring_clk_i(ring), .lf_clk_i(lf), .clk_sel_i(sel),
    .rst_mode_i(rmode), .rst_to_cnt_i(rstv), .cnt_val_i(mval), .rst_in_i(rin),
    .keep_i(keep), .up_i(up), .term_o(term_w), .err_o(err_w), .count_o(cnt_w));

  prescaled_updown_counter #(.DEPTH(8), .WIDE_SEL(1'b0)) i_prescaled_updown_counter_n (
    .clk(clk), .rst_n(rst_n), .ring_clk_i(ring), .lf_clk_i(lf), .clk_sel_i(sel),
    .rst_mode_i(rmode), .rst_to_cnt_i(rstv), .cnt_val_i(mval), .rst_in_i(rin),
    .keep_i(keep), .up_i(up), .term_o(term_n), .err_o(err_n), .count_o(cnt_n));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [8:0] mstep(logic [7:0] q, logic k, logic u, logic [7:0] m);
    if (k) return {1'b0, q};
    if (u) return (q >= m) ? {1'b1, 8'd0} : {1'b0, q + 8'd1};
    return (q == 8'd0) ? {1'b1, m} : {1'b0, q - 8'd1};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mq = 8'd0;
    mt = 1'b0;
  endtask

  // one main-clock step with the divide-by-1 source; ld forces a reset load
  task automatic step_chk(input logic k, input logic ld, input string req);
    keep = k;
    @(posedge clk);
    if (ld) begin
      mq = rstv ? mval : 8'd0;
      mt = 1'b0;
    end else begin
      {mt, mq} = mstep(mq, k, up, mval);
    end
    @(negedge clk);
    chk(req, int'(cnt_w), int'(mq));
    chk(req, int'(term_w), int'(mt));
  endtask

  function automatic int exp_div(int c, bit wide);
    if (wide) case (c) 0: return 1; 1: return 4; 2: return 12; 3: return 24; 4: return 64; default: return 0; endcase
    case (c) 0: return 1; 1: return 4; 2: return 24; 3: return 64; default: return 0; endcase
  endfunction

  function automatic int exp_alt(int c, bit wide); // 1 ring, 2 low-frequency
    if (wide) return (c == 8) ? 1 : (c == 10) ? 2 : 0;
    return (c == 6) ? 1 : (c == 4) ? 2 : 0;
  endfunction

  task automatic dec_eval(input bit wide, input int c, input logic [7:0] dm,
                          input logic [7:0] da, input logic e);
    string tag;
    int n, a;
    tag = wide ? "R1" : "R2";
    n = exp_div(c, wide);
    a = exp_alt(c, wide);
    if (n == 0 && a == 0) begin
      chk("R10 err", int'(e), 1);
      chk("R10 frozen", int'(dm), 0);
      chk("R10 frozen alt", int'(da), 0);
    end else begin
      chk({tag, " err"}, int'(e), 0);
      if (n != 0) chk({tag, " divide"}, int'(dm), 192 / n);
      else begin
        chk({tag, " alt idle main"}, int'(dm), 0);
        chk({tag, " alt count"}, int'(da), (a == 1) ? 3 : 6);
      end
    end
  endtask

  initial begin
    logic [7:0] a0, a1, a2, b0, b1, b2;
    @(negedge clk);
    // R6, R7, R8: direction, hold and terminal sweep over limits 0..7
    for (int m = 0; m < 8; m++) begin
      for (int u = 0; u < 2; u++) begin
        sel = 4'd0; rmode = 2'd2; rin = 1'b0; rstv = 1'b0;
        mval = 8'(m); up = u[0]; keep = 1'b1;
        do_reset();
        if (m == 0 && u == 0) begin
          chk("reset count", int'(cnt_w), 0);
          chk("reset term", int'(term_w), 0);
          chk("reset err", int'(err_w), 0);
        end
        for (int i = 0; i < 20; i++)
          step_chk(i % 3 == 2, 1'b0, u ? "R7/R6" : "R8/R6");
      end
    end

    // R3, R4, R5: reset load colliding with count steps and a wrap (limit 2)
    for (int md = 0; md < 4; md++) begin
      for (int r = 0; r < 2; r++) begin
        sel = 4'd0; rmode = 2'(md); rstv = r[0]; mval = 8'd2; up = 1'b1;
        keep = 1'b0; rin = 1'b0;
        do_reset();
        rin = 1'b1;
        for (int i = 1; i <= 8; i++)
          step_chk(1'b0, (md == 3 && i >= 3) || ((md == 0 || md == 2) && i == 3),
                   (md == 3) ? "R4/R5 rise" : "R3/R5 rise");
        rin = 1'b0;
        for (int i = 1; i <= 6; i++)
          step_chk(1'b0, (md == 3 && i <= 2) || ((md == 0 || md == 1) && i == 3),
                   (md == 3) ? "R4/R5 fall" : "R3/R5 fall");
      end
    end

    // R9: phase restart on source change
    sel = 4'd3; rmode = 2'd2; rstv = 1'b0; mval = 8'hFF; up = 1'b1; keep = 1'b0; rin = 1'b0;
    do_reset();
    repeat (20) @(negedge clk);
    chk("R9 before change", int'(cnt_w), 0);
    sel = 4'd2;
    repeat (12) @(negedge clk);
    chk("R9 no strobe yet", int'(cnt_w), 0);
    @(negedge clk);
    chk("R9 first strobe", int'(cnt_w), 1);

    // R1, R2, R10: source decode sweep for both variants
    for (int c = 0; c < 16; c++) begin
      sel = 4'(c); rmode = 2'd2; rstv = 1'b0; mval = 8'hFF; up = 1'b1; keep = 1'b0; rin = 1'b0;
      do_reset();
      repeat (5) @(negedge clk);
      a0 = cnt_w; b0 = cnt_n;
      repeat (192) @(negedge clk);
      a1 = cnt_w; b1 = cnt_n;
      for (int k = 0; k < 3; k++) begin
        ring = 1'b1; repeat (5) @(negedge clk);
        ring = 1'b0; repeat (5) @(negedge clk);
      end
      for (int k = 0; k < 6; k++) begin
        lf = 1'b1; repeat (5) @(negedge clk);
        lf = 1'b0; repeat (5) @(negedge clk);
      end
      repeat (5) @(negedge clk);
      a2 = cnt_w; b2 = cnt_n;
      dec_eval(1'b1, c, a1 - a0, a2 - a1, err_w);
      dec_eval(1'b0, c, b1 - b0, b2 - b1, err_n);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule